// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the register-level controller of an eight-channel analog-to-digital converter. Software writes one 32-bit control word to choose a channel, pick the internal or the external reference, set a clock divider and start a conversion. The block then counts converter cycles, latches a 10-bit code into a read-only result word, raises a completion flag and, when allowed, an interrupt. A separate self-reset, also timed in converter cycles, cancels any work in flight and clears the enable bit when it ends.

The analog side is modelled digitally. Each channel's voltage arrives on a port as a value in microvolts, and so do both references. At the end of a conversion the block divides the selected input by the selected reference. The register port is a plain single-cycle bus: a select, a write strobe, a byte address, write data and combinational read data. Word offset 0x0 is the control word. Word offset 0x4 is the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word, the result word and `irq` all read 0.
- R2: Control bit positions: channel select at bits 26:24, interrupt enable bit 21, reference select bit 19, completion flag bit 18, enable bit 17, reset bit 16, convert/busy bit 13, divider bits 8:1. Every other bit reads 0. Channel, interrupt enable, reference select, enable and divider read back as written.
- R3: A write with convert=1 and enable=1 starts a conversion. The convert bit reads 1 for exactly 20 converter cycles and then clears. A converter cycle lasts 2×(divider+1) clock periods with the default prescale shift of 0.
- R4: The result word holds floor(input×1024/reference) in bits 9:0, saturated at 1023, with bits 31:10 at 0. A zero reference gives 1023. Reference select 1 uses `int_ref_uv`; reference select 0 uses `ext_ref_uv`.
- R5: The channel-select field picks which 32-bit slice of `ch_uv` is converted. Channel k is bits 32k+31:32k.
- R6: When a conversion completes, the flag is set. Writing 1 to bit 18 clears it. Writing 0 to bit 18 leaves it unchanged.
- R7: `irq` is high exactly while the flag and interrupt enable are both 1.
- R8: A write with the reset bit set starts a reset of 10 converter cycles. During the reset the reset bit reads 1, and the convert bit and the flag read 0. Any running conversion is abandoned and the result is left unchanged. At the end the reset bit and the enable bit read 0.
- R9: A write with convert=1 and enable=0 starts nothing. The convert bit reads 0 at once, and the result and flag stay unchanged.
- R10: The result word keeps its value until the next conversion completes, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W (3) | Byte address: 0 control, 4 result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ch_uv | input | NCH*VAL_W (256) | Channel inputs in microvolts, channel k in slice k |
| int_ref_uv | input | VAL_W (32) | Internal reference in microvolts |
| ext_ref_uv | input | VAL_W (32) | External reference in microvolts |
| irq | output | 1 | Completion interrupt |

## Verification
The bench samples the busy bit one clock before and one clock after the twentieth converter cycle, across several divider values. A wrong prescale or an off-by-one cycle count therefore shows as a busy bit that clears early or stays set late. The conversion table covers saturation at full scale, a zero reference, a zero input and both reference sources. Every non-selected channel carries a distinct decoy value, so a wrong multiplexer or reference choice yields a wrong code. The directed tests aim at three hazards: a flag that a write of 0 clears, an interrupt that ignores its enable, and a convert request without enable that still runs. A self-reset that aborts a conversion must leave the old result intact and must take exactly ten converter cycles before the enable bit drops.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
   localparam int BIT_CONV   = 13;
   localparam int BIT_RST    = 16;
   localparam int BIT_EN     = 17;
   localparam int BIT_FLAG   = 18;
   localparam int BIT_REFSEL = 19;
   localparam int BIT_IE     = 21;
   localparam int MUX_LSB    = 24;
   localparam int DIV_LSB    = 1;
   localparam int REG_W      = 32;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CONV = 2'd1,
      SEQ_RST  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
   parameter int DIV_W     = 8,
   parameter int PRE_SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = DIV_W + 2 + PRE_SHIFT;

   if (DIV_W < 1) begin : g_bad_div
      $error("adc_tick_gen: DIV_W must be at least 1");
   end
   if (PRE_SHIFT < 0) begin : g_bad_shift
      $error("adc_tick_gen: PRE_SHIFT must not be negative");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] last;

   always_comb begin
      period = (CNT_W'(div) + CNT_W'(1)) << (PRE_SHIFT + 1);
      last   = period - CNT_W'(1);
      tick   = (cnt_q == last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || tick)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_ctl_pkg::*;
#(
   parameter int CONV_CYC = 20,
   parameter int RST_CYC  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_conv,
   input  logic start_rst,
   input  logic tick,
   output logic busy,
   output logic resetting,
   output logic conv_done,
   output logic rst_done
);
   localparam int MAX_CYC = (CONV_CYC > RST_CYC) ? CONV_CYC : RST_CYC;
   localparam int CW      = $clog2(MAX_CYC + 1);

   if (CONV_CYC < 1 || RST_CYC < 1) begin : g_bad_len
      $error("adc_seq_fsm: cycle counts must be positive");
   end

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;

   always_comb begin
      busy      = (state_q == SEQ_CONV);
      resetting = (state_q == SEQ_RST);
      conv_done = busy && tick && (cnt_q == CW'(CONV_CYC - 1)) && !start_rst;
      rst_done  = resetting && tick && (cnt_q == CW'(RST_CYC - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else if (start_rst) begin
         state_q <= SEQ_RST;
         cnt_q   <= '0;
      end else if (start_conv && state_q == SEQ_IDLE) begin
         state_q <= SEQ_CONV;
         cnt_q   <= '0;
      end else if (conv_done || rst_done) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else if (tick && state_q != SEQ_IDLE) begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/adc_quant.sv
module adc_quant #(
   parameter int NCH    = 8,
   parameter int VAL_W  = 32,
   parameter int CODE_W = 10,
   parameter int SEL_W  = $clog2(NCH)
) (
   input  logic [NCH*VAL_W-1:0] ch_bus,
   input  logic [SEL_W-1:0]     sel,
   input  logic [VAL_W-1:0]     ref_val,
   output logic [CODE_W-1:0]    code
);
   localparam int PROD_W = VAL_W + CODE_W;
   localparam logic [PROD_W-1:0] FULL = PROD_W'((1 << CODE_W) - 1);

   logic [VAL_W-1:0]  ch_arr [NCH];
   logic [VAL_W-1:0]  vin;
   logic [PROD_W-1:0] scaled;
   logic [PROD_W-1:0] quot;

   for (genvar g = 0; g < NCH; g++) begin : g_slice
      assign ch_arr[g] = ch_bus[g*VAL_W +: VAL_W];
   end

   always_comb begin
      vin    = ch_arr[sel];
      scaled = {vin, CODE_W'(0)};
      if (ref_val == '0) quot = {PROD_W{1'b1}};
      else               quot = scaled / PROD_W'(ref_val);
      code   = (quot > FULL) ? FULL[CODE_W-1:0] : quot[CODE_W-1:0];
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_ctl_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int VAL_W     = 32,
   parameter int CODE_W    = 10,
   parameter int DIV_W     = 8,
   parameter int PRE_SHIFT = 0,
   parameter int CONV_CYC  = 20,
   parameter int RST_CYC   = 10,
   parameter int ADDR_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NCH*VAL_W-1:0] ch_uv,
   input  logic [VAL_W-1:0]     int_ref_uv,
   input  logic [VAL_W-1:0]     ext_ref_uv,
   output logic                 irq
);
   localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_RES = ADDR_W'(4);

   if ((1 << SEL_W) != NCH) begin : g_bad_nch
      $error("adc_seq_ctrl: NCH must be a power of two, at least 2");
   end
   if (MUX_LSB + SEL_W > REG_W) begin : g_bad_sel
      $error("adc_seq_ctrl: channel field exceeds the register");
   end
   if (DIV_LSB + DIV_W > BIT_CONV) begin : g_bad_divw
      $error("adc_seq_ctrl: divider field overlaps the convert bit");
   end
   if (CODE_W > REG_W || ADDR_W < 3) begin : g_bad_geom
      $error("adc_seq_ctrl: result width or address width out of range");
   end

   logic [SEL_W-1:0]  mux_q;
   logic [DIV_W-1:0]  div_q;
   logic              ie_q, refsel_q, en_q, flag_q;
   logic [CODE_W-1:0] res_q;
   logic [CODE_W-1:0] code;
   logic [VAL_W-1:0]  ref_sel;
   logic              seq_busy, seq_rst, conv_done, rst_done, tick;
   logic              ctl_hit, res_hit, wr_ctl, start_conv, start_rst;
   logic [31:0]       ctl_rd;
   logic              wdata_unused;

   assign wdata_unused = ^bus_wdata;

   always_comb begin
      ctl_hit    = bus_sel && (bus_addr == OFS_CTL);
      res_hit    = bus_sel && (bus_addr == OFS_RES);
      wr_ctl     = ctl_hit && bus_wr;
      start_rst  = wr_ctl && bus_wdata[BIT_RST] && !seq_rst;
      start_conv = wr_ctl && bus_wdata[BIT_CONV] && bus_wdata[BIT_EN]
                   && !bus_wdata[BIT_RST] && !seq_rst && !seq_busy;
      ref_sel    = refsel_q ? int_ref_uv : ext_ref_uv;
   end

   adc_tick_gen #(.DIV_W(DIV_W), .PRE_SHIFT(PRE_SHIFT)) i_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_conv || start_rst),
      .div     (div_q),
      .tick    (tick)
   );

   adc_seq_fsm #(.CONV_CYC(CONV_CYC), .RST_CYC(RST_CYC)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_conv (start_conv),
      .start_rst  (start_rst),
      .tick       (tick),
      .busy       (seq_busy),
      .resetting  (seq_rst),
      .conv_done  (conv_done),
      .rst_done   (rst_done)
   );

   adc_quant #(.NCH(NCH), .VAL_W(VAL_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) i_quant (
      .ch_bus  (ch_uv),
      .sel     (mux_q),
      .ref_val (ref_sel),
      .code    (code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mux_q    <= '0;
         div_q    <= '0;
         ie_q     <= 1'b0;
         refsel_q <= 1'b0;
         en_q     <= 1'b0;
         flag_q   <= 1'b0;
         res_q    <= '0;
      end else begin
         if (wr_ctl) begin
            mux_q    <= bus_wdata[MUX_LSB +: SEL_W];
            div_q    <= bus_wdata[DIV_LSB +: DIV_W];
            ie_q     <= bus_wdata[BIT_IE];
            refsel_q <= bus_wdata[BIT_REFSEL];
            en_q     <= bus_wdata[BIT_EN];
         end
         if (rst_done) en_q <= 1'b0;

         if (start_rst || seq_rst)                flag_q <= 1'b0;
         else if (conv_done)                      flag_q <= 1'b1;
         else if (wr_ctl && bus_wdata[BIT_FLAG])  flag_q <= 1'b0;

         if (conv_done) res_q <= code;
      end
   end

   always_comb begin
      ctl_rd                        = '0;
      ctl_rd[MUX_LSB +: SEL_W]      = mux_q;
      ctl_rd[DIV_LSB +: DIV_W]      = div_q;
      ctl_rd[BIT_IE]                = ie_q;
      ctl_rd[BIT_REFSEL]            = refsel_q;
      ctl_rd[BIT_FLAG]              = flag_q;
      ctl_rd[BIT_EN]                = en_q;
      ctl_rd[BIT_RST]               = seq_rst;
      ctl_rd[BIT_CONV]              = seq_busy;
      if (res_hit)      bus_rdata = 32'(res_q);
      else if (ctl_hit) bus_rdata = ctl_rd;
      else              bus_rdata = '0;
      irq = flag_q && ie_q;
   end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              resetting,
   input logic              flag,
   input logic              en,
   input logic [CODE_W-1:0] res
);
   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !resetting) |-> flag);                    // R6
   AST_RST_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      resetting |-> (!busy && !flag));                         // R8
   AST_RST_END_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resetting) |-> !en);                               // R8
   AST_RES_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(res));                          // R10
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> en);                                     // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (seq_busy),
   .resetting (seq_rst),
   .flag      (flag_q),
   .en        (en_q),
   .res       (res_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 8;
   localparam int VW         = 32;
   localparam int DECOY      = 300000;

   typedef struct packed {
      logic [2:0]  ch;
      logic        refsel;
      logic [7:0]  div;
      logic [31:0] vin;
      logic [31:0] refv;
      logic [9:0]  code;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 1'b1, 8'd0, 32'd500000,  32'd2000000, 10'd256},
      '{3'd3, 1'b0, 8'd1, 32'd1000000, 32'd2500000, 10'd409},
      '{3'd7, 1'b1, 8'd3, 32'd2000000, 32'd2000000, 10'd1023},
      '{3'd5, 1'b0, 8'd0, 32'd1800000, 32'd2200000, 10'd837},
      '{3'd2, 1'b1, 8'd2, 32'd100000,  32'd2000000, 10'd51},
      '{3'd6, 1'b0, 8'd0, 32'd1500000, 32'd2000000, 10'd768},
      '{3'd1, 1'b1, 8'd0, 32'd0,       32'd2000000, 10'd0},
      '{3'd4, 1'b0, 8'd1, 32'd5,       32'd0,       10'd1023}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sel = 1'b0;
   logic              wr = 1'b0;
   logic [2:0]        addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [NCH*VW-1:0] ch_uv = '0;
   logic [31:0]       iref = 32'd2000000;
   logic [31:0]       eref = 32'd2000000;
   logic              irq;
   int                checks = 0;
   int                errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (sel),
      .bus_wr     (wr),
      .bus_addr   (addr),
      .bus_wdata  (wdata),
      .bus_rdata  (rdata),
      .ch_uv      (ch_uv),
      .int_ref_uv (iref),
      .ext_ref_uv (eref),
      .irq        (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic fill_decoys();
      for (int k = 0; k < NCH; k++) ch_uv[k*VW +: VW] = DECOY;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [31:0] ctl;
      int          p;
      fill_decoys();
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(1);

      // R1 reset state
      bus_read(3'd0, d); chk("R1 ctl", d, 32'h0);
      bus_read(3'd4, d); chk("R1 result", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 field readback, flag write-one on clear flag, unused bits
      bus_write(3'd0, 32'h000C_0000);
      bus_read(3'd0, d); chk("R2 refsel only", d, 32'h0008_0000);
      bus_write(3'd0, 32'hF72C_E1FF & ~32'h0006_2000);
      bus_read(3'd0, d); chk("R2 fields", d, 32'h0728_01FE);
      chk("R7 ie without flag", {31'b0, irq}, 32'h0);

      // R3 R4 R5 table of conversions
      for (int i = 0; i < 8; i++) begin
         vec_t v = VECS[i];
         p = 2 * (int'(v.div) + 1);
         fill_decoys();
         ch_uv[int'(v.ch)*VW +: VW] = v.vin;
         if (v.refsel) begin iref = v.refv; eref = 32'd1000000; end
         else          begin eref = v.refv; iref = 32'd2000000; end
         ctl = (32'(v.ch) << 24) | (32'(v.refsel) << 19) | 32'h0002_0000
               | (32'(v.div) << 1);
         bus_write(3'd0, ctl | 32'h0004_2000);
         wait_clk(10*p);
         bus_read(3'd0, d); chk("R3 busy at 10 cycles", {31'b0, d[13]}, 32'h1);
         wait_clk(10*p - 1);
         bus_read(3'd0, d); chk("R3 busy before 20th", {31'b0, d[13]}, 32'h1);
         wait_clk(1);
         bus_read(3'd0, d); chk("R3 idle after 20th", {31'b0, d[13]}, 32'h0);
         wait_clk(10*p);
         bus_read(3'd0, d); chk("R6 ctl after done", d, ctl | 32'h0004_0000);
         bus_read(3'd4, d); chk("R4 R5 code", d, 32'(v.code));
         chk("R7 irq masked", {31'b0, irq}, 32'h0);
      end

      // R6 R7 interrupt gating and flag clearing
      fill_decoys();
      ch_uv[1*VW +: VW] = 32'd500000;
      iref = 32'd2000000;
      bus_write(3'd0, 32'h012E_2000);
      wait_clk(60);
      chk("R7 irq set", {31'b0, irq}, 32'h1);
      bus_read(3'd0, d); chk("R6 flag set", d, 32'h012E_0000);
      bus_write(3'd0, 32'h010A_0000);
      chk("R7 irq off by ie", {31'b0, irq}, 32'h0);
      bus_read(3'd0, d); chk("R6 zero write keeps flag", d, 32'h010E_0000);
      bus_write(3'd0, 32'h012A_0000);
      chk("R7 irq back", {31'b0, irq}, 32'h1);
      bus_write(3'd0, 32'h012E_0000);
      chk("R7 irq after clear", {31'b0, irq}, 32'h0);
      bus_read(3'd0, d); chk("R6 flag cleared", d, 32'h012A_0000);

      // R10 result holds while inputs change
      ch_uv[1*VW +: VW] = 32'd1900000;
      wait_clk(5);
      bus_read(3'd4, d); chk("R10 result held", d, 32'd256);

      // R9 convert without enable
      bus_write(3'd0, 32'h0108_2000);
      bus_read(3'd0, d); chk("R9 no start", d, 32'h0108_0000);
      wait_clk(60);
      bus_read(3'd4, d); chk("R9 result unchanged", d, 32'd256);
      bus_read(3'd0, d); chk("R9 no flag", d, 32'h0108_0000);

      // R8 reset aborting a conversion, divider 3
      bus_write(3'd0, 32'h010A_2000);
      wait_clk(3);
      bus_write(3'd0, 32'h0003_0006);
      bus_read(3'd0, d); chk("R8 during reset", d, 32'h0003_0006);
      wait_clk(79);
      bus_read(3'd0, d); chk("R8 still resetting", {31'b0, d[16]}, 32'h1);
      wait_clk(1);
      bus_read(3'd0, d); chk("R8 reset over", d, 32'h0000_0006);
      bus_read(3'd4, d); chk("R8 result kept", d, 32'd256);
      chk("R8 irq low", {31'b0, irq}, 32'h0);

      // R8 reset with divider 0
      bus_write(3'd0, 32'h0003_0000);
      wait_clk(19);
      bus_read(3'd0, d); chk("R8 div0 resetting", d, 32'h0003_0000);
      wait_clk(1);
      bus_read(3'd0, d); chk("R8 div0 over", d, 32'h0);

      finish_run();
   end
endmodule